// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Generator

This block derives the bit timing for one serial channel from the system clock. The length of a bit is set by an 8-bit divisor, a 2-bit prescale select, a channel mode and, in smart card mode, a 2-bit per-bit cycle-count code. The prescale select multiplies the bit length by four at each step. Smart card mode can use a cycle count of 372, which is not a power of two. The block produces two single-cycle strobes. The first marks the end of each bit period. The second marks the middle of the period, where a receiver would sample the line.

Configuration is written through a plain write port. All fields are written together in one cycle, and each field can be read back at any time. A write made while the channel is running does not change the timing. Such a write is dropped and raises an error flag, which stays set until the run input goes low. Raising the run input restarts the internal counters, so the first strobe always comes exactly one full period later. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `brg_bit_rate_gen`

## Requirements
- R1: After reset the divisor reads 255, the prescale select reads 0, the cycle-count code reads 0, the mode reads 0 (asynchronous), and both strobes and the error flag are low.
- R2: In asynchronous mode (mode code 0) a bit period is 32 × 4^n × (N+1) clocks, where n is the prescale select and N is the divisor.
- R3: In clocked synchronous mode (mode code 1) a bit period is 4 × 4^n × (N+1) clocks.
- R4: In smart card mode (mode code 2) a bit period is 2 × S × 4^n × (N+1) clocks. S is selected by the cycle-count code: 0 gives 32, 1 gives 64, 2 gives 372 and 3 gives 256. In the other modes the code has no effect.
- R5: Counting rising edges at which run is sampled high, starting at 1 on the first such edge, bit_stb is high in the cycle after edge P, then after edge 2P, and so on, where P is the bit period.
- R6: mid_stb is high once per period: in the cycle after edge floor(P/2), then after edge P + floor(P/2), and so on.
- R7: Each strobe lasts one cycle. The two strobes are never high together. Both strobes are low in any cycle that follows an edge at which run was low.
- R8: A write with run low is captured at that edge. From the next cycle the new values appear on the read-back outputs and set the period.
- R9: A write at an edge where run is high is ignored: the read-back values and the timing do not change, and wr_err is set in the next cycle. wr_err clears at the first edge at which run is sampled low.
- R10: Mode code 3 gives the same bit period as asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel running; counters held at zero while low |
| cfg_we | input | 1 | Write strobe for all configuration fields |
| cfg_div | input | 8 | Divisor N to write |
| cfg_cks | input | 2 | Prescale select n to write |
| cfg_scs | input | 2 | Smart card cycle-count code to write |
| cfg_mode | input | 2 | Mode code to write (0 async, 1 sync, 2 smart card, 3 as async) |
| div_rd | output | 8 | Current divisor |
| cks_rd | output | 2 | Current prescale select |
| scs_rd | output | 2 | Current cycle-count code |
| mode_rd | output | 2 | Current mode code |
| wr_err | output | 1 | A write arrived while running |
| bit_stb | output | 1 | Bit-boundary strobe |
| mid_stb | output | 1 | Mid-bit sample strobe |

## Verification
The assertions check on every cycle that the strobes are single-cycle and never overlap, and that both stay quiet after run is low. They also check that configuration is frozen while running, and how the error flag is set and cleared. Only the bench scenarios can show that the strobe positions match the period formulas. The bench measures the first and second bit and mid strobes from the rise of run for every mode, prescale select and cycle-count code. It uses divisors 0, 1, 127 and 255 wherever the period fits the run budget.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int DIV_W = 8;
  localparam int SEL_W = 2;
  localparam int PRE_W = 16;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_SCARD = 2'd2,
    MODE_ALT   = 2'd3
  } brg_mode_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] cks;
    logic [SEL_W-1:0] scs;
    brg_mode_e        mode;
  } brg_cfg_t;

  localparam brg_cfg_t CFG_RESET = '{div: '1, cks: '0, scs: '0, mode: MODE_ASYNC};
endpackage

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
  import brg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_en,
  input  logic     we,
  input  brg_cfg_t wr_cfg,
  output brg_cfg_t cfg,
  output logic     err
);
  brg_cfg_t cfg_q;
  logic     err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else begin
      if (we && !run_en) cfg_q <= wr_cfg;
      err_q <= run_en ? (err_q | we) : 1'b0;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;
endmodule

// File: rtl/brg_period_calc.sv
module brg_period_calc
  import brg_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  brg_cfg_t     cfg,
  output logic [W-1:0] pre_len
);
  logic [W-1:0] base;

  always_comb begin
    unique case (cfg.mode)
      MODE_SYNC:  base = W'(4);
      MODE_SCARD: begin
        unique case (cfg.scs)
          2'd0:    base = W'(64);
          2'd1:    base = W'(128);
          2'd2:    base = W'(744);
          default: base = W'(512);
        endcase
      end
      default:    base = W'(32);
    endcase
  end

  assign pre_len = base << {cfg.cks, 1'b0};
endmodule

// File: rtl/brg_bit_timer.sv
module brg_bit_timer
  import brg_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [PW-1:0] pre_len,
  input  logic [DW-1:0] div,
  output logic          bit_stb,
  output logic          mid_stb
);
  localparam int NSTB = 2;

  logic [PW-1:0] pre_q, pre_nx, half_pre;
  logic [DW-1:0] div_q, div_nx, half_div;
  logic          pre_wrap, div_wrap, mid_hit;
  logic [NSTB-1:0] stb_d, stb_q;

  always_comb begin
    pre_wrap = (pre_q == pre_len - PW'(1));
    div_wrap = pre_wrap && (div_q == div);
    pre_nx   = pre_wrap ? '0 : pre_q + PW'(1);
    div_nx   = pre_wrap ? (div_wrap ? '0 : div_q + DW'(1)) : div_q;
    half_div = (div >> 1) + DW'(div[0]);
    half_pre = div[0] ? '0 : (pre_len >> 1);
    mid_hit  = (div_nx == half_div) && (pre_nx == half_pre);
    stb_d    = {mid_hit, div_wrap};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!run_en) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_nx;
      div_q <= div_nx;
    end
  end

  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[i] <= 1'b0;
      else        stb_q[i] <= run_en && stb_d[i];
    end
  end

  assign bit_stb = stb_q[0];
  assign mid_stb = stb_q[1];
endmodule

// File: rtl/brg_bit_rate_gen.sv
module brg_bit_rate_gen
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       cfg_we,
  input  logic [7:0] cfg_div,
  input  logic [1:0] cfg_cks,
  input  logic [1:0] cfg_scs,
  input  logic [1:0] cfg_mode,
  output logic [7:0] div_rd,
  output logic [1:0] cks_rd,
  output logic [1:0] scs_rd,
  output logic [1:0] mode_rd,
  output logic       wr_err,
  output logic       bit_stb,
  output logic       mid_stb
);
  brg_cfg_t         wr_cfg, cfg;
  logic [PRE_W-1:0] pre_len;

  assign wr_cfg = '{div: cfg_div, cks: cfg_cks, scs: cfg_scs, mode: brg_mode_e'(cfg_mode)};

  brg_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .we(cfg_we),
    .wr_cfg(wr_cfg), .cfg(cfg), .err(wr_err)
  );

  brg_period_calc #(.W(PRE_W)) u_calc (.cfg(cfg), .pre_len(pre_len));

  brg_bit_timer #(.PW(PRE_W), .DW(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_len(pre_len),
    .div(cfg.div), .bit_stb(bit_stb), .mid_stb(mid_stb)
  );

  assign div_rd  = cfg.div;
  assign cks_rd  = cfg.cks;
  assign scs_rd  = cfg.scs;
  assign mode_rd = cfg.mode;
endmodule

// File: rtl/brg_bit_rate_gen_chk.sv
module brg_bit_rate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       cfg_we,
  input logic [7:0] cfg_div,
  input logic [7:0] div_rd,
  input logic [1:0] cks_rd,
  input logic [1:0] scs_rd,
  input logic [1:0] mode_rd,
  input logic       wr_err,
  input logic       bit_stb,
  input logic       mid_stb
);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_stb && mid_stb));
  // R7
  bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
  // R7
  mid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |=> !mid_stb);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!bit_stb && !mid_stb));
  // R8
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !run_en) |=> (div_rd == $past(cfg_div)));
  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(div_rd) && $stable(cks_rd) && $stable(scs_rd) && $stable(mode_rd)));
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cfg_we) |=> wr_err);
  // R9
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !wr_err);
endmodule

bind brg_bit_rate_gen brg_bit_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we), .cfg_div(cfg_div),
  .div_rd(div_rd), .cks_rd(cks_rd), .scs_rd(scs_rd), .mode_rd(mode_rd),
  .wr_err(wr_err), .bit_stb(bit_stb), .mid_stb(mid_stb)
);

// File: tb/brg_bit_rate_gen_bench.sv
module brg_bit_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [1:0] cfg_cks = '0, cfg_scs = '0, cfg_mode = '0;
  logic [7:0] div_rd;
  logic [1:0] cks_rd, scs_rd, mode_rd;
  logic       wr_err, bit_stb, mid_stb;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  localparam int MAX_P = 2048;
  localparam int WDOG = 190000;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brg_bit_rate_gen u_brg_bit_rate_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_cks(cfg_cks), .cfg_scs(cfg_scs), .cfg_mode(cfg_mode),
    .div_rd(div_rd), .cks_rd(cks_rd), .scs_rd(scs_rd), .mode_rd(mode_rd),
    .wr_err(wr_err), .bit_stb(bit_stb), .mid_stb(mid_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int md, input int cks, input int scs, input int nv);
    int base;
    int s;
    s = (scs == 0) ? 32 : (scs == 1) ? 64 : (scs == 2) ? 372 : 256;
    base = (md == 1) ? 4 : (md == 2) ? 2 * s : 32;
    return base * (4 ** cks) * (nv + 1);
  endfunction

  task automatic write_cfg(input int md, input int cks, input int scs, input int nv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 8'(nv); cfg_cks = 2'(cks); cfg_scs = 2'(scs); cfg_mode = 2'(md);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cfg(input int md, input int cks, input int scs, input int nv, input string req);
    int per, m1, m2, b1, b2;
    per = exp_period(md, cks, scs, nv);
    m1 = -1; m2 = -1; b1 = -1; b2 = -1;
    write_cfg(md, cks, scs, nv);
    // R8: readback of the freshly written fields
    check(div_rd == 8'(nv) && mode_rd == 2'(md) && cks_rd == 2'(cks) && scs_rd == 2'(scs),
          "R8 readback", int'(div_rd), nv);
    @(negedge clk);
    run_en = 1'b1;
    for (int k = 1; k <= 2 * per + 2; k++) begin
      @(posedge clk); #1;
      if (mid_stb) begin if (m1 < 0) m1 = k; else if (m2 < 0) m2 = k; end
      if (bit_stb) begin if (b1 < 0) b1 = k; else if (b2 < 0) b2 = k; end
    end
    check(b1 == per, {req, "/R5 first bit"}, b1, per);
    check(b2 == 2 * per, {req, "/R5 second bit"}, b2, 2 * per);
    check(m1 == per / 2, {req, "/R6 first mid"}, m1, per / 2);
    check(m2 == per + per / 2, {req, "/R6 second mid"}, m2, per + per / 2);
    @(negedge clk);
    run_en = 1'b0;
  endtask

  initial begin
    int nvals[4];
    nvals = '{0, 1, 127, 255};
    #12;
    // R1: reset values
    check(div_rd == 8'hFF, "R1 div", int'(div_rd), 255);
    check(cks_rd == 0 && scs_rd == 0 && mode_rd == 0, "R1 fields", int'({cks_rd, scs_rd, mode_rd}), 0);
    check(!bit_stb && !mid_stb && !wr_err, "R1 outputs", int'({bit_stb, mid_stb, wr_err}), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int cks = 0; cks < 4; cks++)
      for (int i = 0; i < 4; i++)
        if (exp_period(0, cks, 0, nvals[i]) <= MAX_P) run_cfg(0, cks, 3, nvals[i], "R2 async");
    for (int cks = 0; cks < 4; cks++)
      for (int i = 0; i < 4; i++)
        if (exp_period(1, cks, 0, nvals[i]) <= MAX_P) run_cfg(1, cks, 2, nvals[i], "R3 sync");
    for (int scs = 0; scs < 4; scs++)
      for (int cks = 0; cks < 4; cks++)
        for (int i = 0; i < 4; i++)
          if (exp_period(2, cks, scs, nvals[i]) <= MAX_P) run_cfg(2, cks, scs, nvals[i], "R4 scard");
    run_cfg(3, 0, 1, 1, "R10 code3");

    // R9: write while running is dropped and flagged
    begin
      int b1;
      b1 = -1;
      write_cfg(0, 0, 0, 3);
      @(negedge clk);
      run_en = 1'b1;
      cfg_we = 1'b1; cfg_div = 8'd0; cfg_mode = 2'd1; cfg_cks = 2'd2;
      @(negedge clk);
      cfg_we = 1'b0;
      check(wr_err, "R9 err set", int'(wr_err), 1);
      check(div_rd == 8'd3 && mode_rd == 0 && cks_rd == 0, "R9 cfg kept", int'(div_rd), 3);
      for (int k = 2; k <= 140; k++) begin
        @(posedge clk); #1;
        if (bit_stb && b1 < 0) b1 = k;
      end
      check(b1 == 128, "R9 timing kept", b1, 128);
      @(negedge clk);
      run_en = 1'b0;
      @(posedge clk); #1;
      check(!wr_err, "R9 err clear", int'(wr_err), 0);
    end

    // R7: both strobes quiet while idle
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); #1;
        if (bit_stb || mid_stb) seen++;
      end
      check(seen == 0, "R7 idle quiet", seen, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule